// File: doc/BRIEF.md
# Dual-Supply Selection Controller

This block decides which of two supply inputs feeds a pair of output power switches. Analog comparators outside the block report, for each supply, whether it sits above its under-voltage threshold and above its high-voltage threshold. Two further flags say whether the shared output node has come within a hysteresis margin of supply one or of supply two. The controller drives one enable per supply switch and a soft-start step code that the switch legs use to lower their resistance in timed steps.

Supply one has absolute priority. Supply two is allowed only while supply one is above its high-voltage limit. Every lockout and recovery delay is counted in ticks of a tick-enable input, so the delays do not depend on the system clock rate. When the block hands the output from one supply to the other, it first opens both switches. It then waits for the output node to settle near the new supply before it starts the soft start of that switch. All comparator and output-near flags pass through a synchroniser before the state machine uses them.

Top module: `dual_supply_selector`

## Requirements
- R1: Out of reset the status reads 0 (all open), both switch enables are low and the step code is 0.
- R2: From the all-open state, once supply one is valid (above under-voltage, not above high-voltage) for CLOSE_TICKS consecutive ticks, its switch closes and the status reads 1 (supply one soft start).
- R3: Supply two is connected only when it is valid and supply one is above its high-voltage threshold. A valid supply two alone, with supply one below under-voltage, leaves everything open.
- R4: A connected supply that stays above high-voltage for HV_OPEN_TICKS ticks, or stays below under-voltage for UV_OPEN_TICKS ticks, has its switch opened. An excursion shorter than its limit has no effect.
- R5: When no supply qualifies, the status reads 0, both enables are low and the step code is 0.
- R6: While on supply two, supply one falling below its high-voltage threshold opens switch two with no lockout delay. The status then reads 6 (hand-back to supply one) if supply one is valid.
- R7: During a hand-over (status 3 toward supply two, status 6 toward supply one) both switches stay open until the output-near flag of the target supply is seen. The target's soft start begins after that.
- R8: The step code is 1 on entry to soft start. It holds while the active output-near flag is low. Otherwise it rises by exactly one every STEP_TICKS ticks until it reaches NUM_STEPS. The status then moves to connected (2 for supply one, 5 for supply two) and the code holds.
- R9: The two switch enables are never high in the same cycle.
- R10: When both supplies could qualify, supply one is the one connected.
- R11: Delay and step timers advance only on cycles with the tick input high. With tick held low, a fault never opens a switch.
- R12: Status encoding: 0 open, 1 soft start one, 2 connected one, 3 hand-over to two, 4 soft start two, 5 connected two, 6 hand-over to one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase enable; timers advance on cycles where it is high |
| sup1AboveUv | input | 1 | Supply one above its under-voltage threshold |
| sup1AboveHv | input | 1 | Supply one above its high-voltage threshold |
| sup2AboveUv | input | 1 | Supply two above its under-voltage threshold |
| sup2AboveHv | input | 1 | Supply two above its high-voltage threshold |
| outNearSup1 | input | 1 | Output node within hysteresis of supply one |
| outNearSup2 | input | 1 | Output node within hysteresis of supply two |
| sw1En | output | 1 | Enable for the supply one switch |
| sw2En | output | 1 | Enable for the supply two switch |
| stepCode | output | $clog2(NUM_STEPS+1) | Soft-start step; 0 off, NUM_STEPS full conduction |
| selState | output | 3 | Current selection state (encoding in R12) |

## Verification
The hardest situations to reach are the two hand-over states. They need a supply to be connected and fully ramped, then a high-voltage crossing on supply one, all while the output-near flag of the target supply is held low. The bench walks the supplies through a fixed sequence of power-up orders and excursions. It parks the controller in each hand-over state long enough to show that neither switch closes, then releases the near flag and checks the soft start that follows. Short under-voltage glitches and a tick-gated fault show that the lockout filters count ticks and not cycles.

// File: rtl/supsel_pkg.sv
package supsel_pkg;

  typedef enum logic [2:0] {
    ST_OPEN  = 3'd0,
    ST_SOFT1 = 3'd1,
    ST_CONN1 = 3'd2,
    ST_XFER2 = 3'd3,
    ST_SOFT2 = 3'd4,
    ST_CONN2 = 3'd5,
    ST_XFER1 = 3'd6
  } selState_t;

  typedef enum logic [1:0] {
    DK_HV     = 2'd0,
    DK_UV     = 2'd1,
    DK_CLOSE1 = 2'd2,
    DK_CLOSE2 = 2'd3
  } dlyKind_t;

  typedef enum logic [1:0] {
    SM_OFF  = 2'd0,
    SM_RUN  = 2'd1,
    SM_HOLD = 2'd2
  } stepMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic      dlyRun;
    dlyKind_t  dlyKind;
    stepMode_t stepMode;
    logic      close1;
    logic      close2;
  } selCtl_t;

  localparam int unsigned FL_S1_UV = 0;
  localparam int unsigned FL_S1_HV = 1;
  localparam int unsigned FL_S2_UV = 2;
  localparam int unsigned FL_S2_HV = 3;
  localparam int unsigned FL_NEAR1 = 4;
  localparam int unsigned FL_NEAR2 = 5;
  localparam int unsigned N_FLAGS  = 6;

endpackage

// File: rtl/supsel_datapath.sv
module supsel_datapath
  import supsel_pkg::*;
#(
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned HV_OPEN_TICKS = 20,
  parameter int unsigned UV_OPEN_TICKS = 200,
  parameter int unsigned CLOSE_TICKS   = 2000,
  parameter int unsigned STEP_TICKS    = 250,
  parameter int unsigned NUM_STEPS     = 4,
  localparam int unsigned STEP_W       = $clog2(NUM_STEPS + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tick,
  input  logic [N_FLAGS-1:0] rawFlags,
  input  selCtl_t            ctl,
  output logic [N_FLAGS-1:0] syncFlags,
  output logic               dlyDone,
  output logic               stepDone,
  output logic [STEP_W-1:0]  stepCode,
  output logic               sw1En,
  output logic               sw2En
);

  localparam int unsigned MAX_A   = (HV_OPEN_TICKS > UV_OPEN_TICKS) ? HV_OPEN_TICKS : UV_OPEN_TICKS;
  localparam int unsigned DLY_MAX = (MAX_A > CLOSE_TICKS) ? MAX_A : CLOSE_TICKS;
  localparam int unsigned DLY_W   = $clog2(DLY_MAX + 1);
  localparam int unsigned TCNT_W  = $clog2(STEP_TICKS + 1);

  localparam logic [DLY_W-1:0]  HV_LIM    = DLY_W'(HV_OPEN_TICKS);
  localparam logic [DLY_W-1:0]  UV_LIM    = DLY_W'(UV_OPEN_TICKS);
  localparam logic [DLY_W-1:0]  CLOSE_LIM = DLY_W'(CLOSE_TICKS);
  localparam logic [TCNT_W-1:0] TCNT_TOP  = TCNT_W'(STEP_TICKS - 1);
  localparam logic [STEP_W-1:0] CODE_TOP  = STEP_W'(NUM_STEPS);

  // ---------------- flag synchronisers ----------------
  for (genvar g = 0; g < N_FLAGS; g++) begin : g_sync
    if (SYNC_STAGES <= 1) begin : g_single
      logic stage;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage <= 1'b0;
        else       stage <= rawFlags[g];
      end
      assign syncFlags[g] = stage;
    end else begin : g_chain
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[SYNC_STAGES-2:0], rawFlags[g]};
      end
      assign syncFlags[g] = chain[SYNC_STAGES-1];
    end
  end

  // ---------------- lockout / recovery delay ----------------
  logic [DLY_W-1:0] dlyCnt;
  logic [DLY_W-1:0] dlyLim;
  dlyKind_t         lastKind;

  always_comb begin
    case (ctl.dlyKind)
      DK_HV:   dlyLim = HV_LIM;
      DK_UV:   dlyLim = UV_LIM;
      default: dlyLim = CLOSE_LIM;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dlyCnt   <= '0;
      lastKind <= DK_UV;
    end else begin
      lastKind <= ctl.dlyKind;
      if (!ctl.dlyRun || (ctl.dlyKind != lastKind)) dlyCnt <= '0;
      else if (tick && (dlyCnt != dlyLim))          dlyCnt <= dlyCnt + DLY_W'(1);
    end
  end

  assign dlyDone = ctl.dlyRun && (ctl.dlyKind == lastKind) && (dlyCnt == dlyLim);

  // ---------------- soft-start step timer ----------------
  logic [TCNT_W-1:0] tCnt;
  logic              nearActive;

  assign nearActive = ctl.close1 ? syncFlags[FL_NEAR1] : syncFlags[FL_NEAR2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepCode <= '0;
      tCnt     <= '0;
    end else begin
      case (ctl.stepMode)
        SM_OFF: begin
          stepCode <= '0;
          tCnt     <= '0;
        end
        SM_RUN: begin
          if (stepCode == '0) begin
            stepCode <= STEP_W'(1);
            tCnt     <= '0;
          end else if (tick && nearActive && (stepCode != CODE_TOP)) begin
            if (tCnt == TCNT_TOP) begin
              tCnt     <= '0;
              stepCode <= stepCode + STEP_W'(1);
            end else begin
              tCnt <= tCnt + TCNT_W'(1);
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign stepDone = (stepCode == CODE_TOP);

  // ---------------- switch enable registers ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sw1En <= 1'b0;
      sw2En <= 1'b0;
    end else begin
      sw1En <= ctl.close1;
      sw2En <= ctl.close2;
    end
  end

endmodule

// File: rtl/supsel_control.sv
module supsel_control
  import supsel_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [N_FLAGS-1:0] syncFlags,
  input  logic               dlyDone,
  input  logic               stepDone,
  output selCtl_t            ctl,
  output selState_t          curState
);

  selState_t nxtState;
  logic s1Uv, s1Hv, s2Uv, s2Hv, near1, near2, s1Valid, s2Valid;

  assign s1Uv    = syncFlags[FL_S1_UV];
  assign s1Hv    = syncFlags[FL_S1_HV];
  assign s2Uv    = syncFlags[FL_S2_UV];
  assign s2Hv    = syncFlags[FL_S2_HV];
  assign near1   = syncFlags[FL_NEAR1];
  assign near2   = syncFlags[FL_NEAR2];
  assign s1Valid = s1Uv && !s1Hv;
  assign s2Valid = s2Uv && !s2Hv;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curState <= ST_OPEN;
    else       curState <= nxtState;
  end

  always_comb begin
    nxtState     = curState;
    ctl          = '0;
    ctl.dlyKind  = DK_UV;
    ctl.stepMode = SM_OFF;
    case (curState)
      ST_OPEN: begin
        // supply one is tested first: it always wins
        if (s1Valid) begin
          ctl.dlyRun  = 1'b1;
          ctl.dlyKind = DK_CLOSE1;
          if (dlyDone) nxtState = ST_SOFT1;
        end else if (s1Hv && s2Valid) begin
          ctl.dlyRun  = 1'b1;
          ctl.dlyKind = DK_CLOSE2;
          if (dlyDone) nxtState = ST_SOFT2;
        end
      end
      ST_SOFT1, ST_CONN1: begin
        ctl.close1   = 1'b1;
        ctl.stepMode = (curState == ST_SOFT1) ? SM_RUN : SM_HOLD;
        if (s1Hv) begin
          ctl.dlyRun  = 1'b1;
          ctl.dlyKind = DK_HV;
          if (dlyDone) nxtState = s2Valid ? ST_XFER2 : ST_OPEN;
        end else if (!s1Uv) begin
          ctl.dlyRun  = 1'b1;
          ctl.dlyKind = DK_UV;
          if (dlyDone) nxtState = ST_OPEN;
        end else if ((curState == ST_SOFT1) && stepDone) begin
          nxtState = ST_CONN1;
        end
      end
      ST_SOFT2, ST_CONN2: begin
        ctl.close2   = 1'b1;
        ctl.stepMode = (curState == ST_SOFT2) ? SM_RUN : SM_HOLD;
        if (!s1Hv) begin
          nxtState = s1Valid ? ST_XFER1 : ST_OPEN;
        end else if (s2Hv) begin
          ctl.dlyRun  = 1'b1;
          ctl.dlyKind = DK_HV;
          if (dlyDone) nxtState = ST_OPEN;
        end else if (!s2Uv) begin
          ctl.dlyRun  = 1'b1;
          ctl.dlyKind = DK_UV;
          if (dlyDone) nxtState = ST_OPEN;
        end else if ((curState == ST_SOFT2) && stepDone) begin
          nxtState = ST_CONN2;
        end
      end
      ST_XFER2: begin
        if (!(s1Hv && s2Valid)) nxtState = ST_OPEN;
        else if (near2)         nxtState = ST_SOFT2;
      end
      ST_XFER1: begin
        if (!s1Valid)   nxtState = ST_OPEN;
        else if (near1) nxtState = ST_SOFT1;
      end
      default: nxtState = ST_OPEN;
    endcase
  end

endmodule

// File: rtl/dual_supply_selector.sv
module dual_supply_selector
  import supsel_pkg::*;
#(
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned HV_OPEN_TICKS = 20,
  parameter int unsigned UV_OPEN_TICKS = 200,
  parameter int unsigned CLOSE_TICKS   = 2000,
  parameter int unsigned STEP_TICKS    = 250,
  parameter int unsigned NUM_STEPS     = 4,
  localparam int unsigned STEP_W       = $clog2(NUM_STEPS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              sup1AboveUv,
  input  logic              sup1AboveHv,
  input  logic              sup2AboveUv,
  input  logic              sup2AboveHv,
  input  logic              outNearSup1,
  input  logic              outNearSup2,
  output logic              sw1En,
  output logic              sw2En,
  output logic [STEP_W-1:0] stepCode,
  output logic [2:0]        selState
);

  logic [N_FLAGS-1:0] rawFlags;
  logic [N_FLAGS-1:0] syncFlags;
  selCtl_t            ctl;
  selState_t          curState;
  logic               dlyDone;
  logic               stepDone;
  logic               s1HvQ;

  assign rawFlags = {outNearSup2, outNearSup1, sup2AboveHv, sup2AboveUv, sup1AboveHv, sup1AboveUv};
  assign s1HvQ    = syncFlags[FL_S1_HV];
  assign selState = curState;

  supsel_datapath #(
    .SYNC_STAGES  (SYNC_STAGES),
    .HV_OPEN_TICKS(HV_OPEN_TICKS),
    .UV_OPEN_TICKS(UV_OPEN_TICKS),
    .CLOSE_TICKS  (CLOSE_TICKS),
    .STEP_TICKS   (STEP_TICKS),
    .NUM_STEPS    (NUM_STEPS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .tick     (tick),
    .rawFlags (rawFlags),
    .ctl      (ctl),
    .syncFlags(syncFlags),
    .dlyDone  (dlyDone),
    .stepDone (stepDone),
    .stepCode (stepCode),
    .sw1En    (sw1En),
    .sw2En    (sw2En)
  );

  supsel_control u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .syncFlags(syncFlags),
    .dlyDone  (dlyDone),
    .stepDone (stepDone),
    .ctl      (ctl),
    .curState (curState)
  );

endmodule

// File: rtl/dual_supply_selector_chk.sv
module dual_supply_selector_chk
  import supsel_pkg::*;
#(
  parameter int unsigned STEP_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              sw1En,
  input logic              sw2En,
  input logic [STEP_W-1:0] stepCode,
  input logic [2:0]        selState,
  input logic              s1HvQ
);

  logic inSup2;
  assign inSup2 = (selState == ST_SOFT2) || (selState == ST_CONN2);

  a_r9_never_both: assert property (@(posedge clk) disable iff (!rstN)
    !(sw1En && sw2En));

  a_r5_open_all_off: assert property (@(posedge clk) disable iff (!rstN)
    (selState == ST_OPEN) && ($past(selState) == ST_OPEN) |-> !sw1En && !sw2En && (stepCode == '0));

  a_r7_handover_open: assert property (@(posedge clk) disable iff (!rstN)
    ((selState == ST_XFER1) || (selState == ST_XFER2)) && ($past(selState) == selState)
      |-> !sw1En && !sw2En);

  a_r8_step_by_one: assert property (@(posedge clk) disable iff (!rstN)
    (stepCode != $past(stepCode)) && ($past(stepCode) != '0) && (stepCode != '0)
      |-> stepCode == $past(stepCode) + STEP_W'(1));

  a_r3_second_needs_first_hv: assert property (@(posedge clk) disable iff (!rstN)
    (selState == ST_SOFT2) && ($past(selState) != ST_SOFT2) |-> $past(s1HvQ));

  a_r6_drop_second: assert property (@(posedge clk) disable iff (!rstN)
    inSup2 && !s1HvQ |=> !((selState == ST_SOFT2) || (selState == ST_CONN2)));

endmodule

bind dual_supply_selector dual_supply_selector_chk #(.STEP_W(STEP_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .sw1En   (sw1En),
  .sw2En   (sw2En),
  .stepCode(stepCode),
  .selState(selState),
  .s1HvQ   (s1HvQ)
);

// File: tb/sim_dual_supply_selector.sv
`timescale 1ns/1ps
module sim_dual_supply_selector;

  localparam int unsigned NUM_STEPS = 4;
  localparam int unsigned STEP_W    = $clog2(NUM_STEPS + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b1;
  logic s1Uv = 1'b0, s1Hv = 1'b0, s2Uv = 1'b0, s2Hv = 1'b0;
  logic near1 = 1'b0, near2 = 1'b0;
  logic sw1En, sw2En;
  logic [STEP_W-1:0] stepCode;
  logic [2:0] selState;

  int cyc = 0;
  int nChecks = 0;
  int nFails = 0;
  int overlaps = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dual_supply_selector #(
    .SYNC_STAGES(2), .HV_OPEN_TICKS(4), .UV_OPEN_TICKS(8),
    .CLOSE_TICKS(16), .STEP_TICKS(5), .NUM_STEPS(NUM_STEPS)
  ) u0 (
    .clk(clk), .rstN(rstN), .tick(tick),
    .sup1AboveUv(s1Uv), .sup1AboveHv(s1Hv),
    .sup2AboveUv(s2Uv), .sup2AboveHv(s2Hv),
    .outNearSup1(near1), .outNearSup2(near2),
    .sw1En(sw1En), .sw2En(sw2En), .stepCode(stepCode), .selState(selState)
  );

  typedef struct {
    int    at;
    logic  e1;
    logic  e2;
    int    eStep;
    int    eState;
    string tag;
  } expItem_t;

  expItem_t expQ[$];

  // driver side: push an expectation dly cycles ahead
  task automatic expectAt(input int dly, input logic e1, input logic e2,
                          input int eStep, input int eState, input string tag);
    expItem_t it;
    it.at = cyc + dly; it.e1 = e1; it.e2 = e2;
    it.eStep = eStep; it.eState = eState; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // monitor side: pop items that fall due, compare away from the edge
  always @(negedge clk) begin
    if (rstN && sw1En && sw2En) overlaps++;
    for (int i = expQ.size() - 1; i >= 0; i--) begin
      if (expQ[i].at == cyc) begin
        nChecks++;
        if (sw1En !== expQ[i].e1 || sw2En !== expQ[i].e2 ||
            (expQ[i].eStep >= 0 && int'(stepCode) != expQ[i].eStep) ||
            (expQ[i].eState >= 0 && int'(selState) != expQ[i].eState)) begin
          nFails++;
          $display("FAIL %s cyc=%0d: actual sw1=%b sw2=%b step=%0d state=%0d expected sw1=%b sw2=%b step=%0d state=%0d",
                   expQ[i].tag, cyc, sw1En, sw2En, stepCode, selState,
                   expQ[i].e1, expQ[i].e2, expQ[i].eStep, expQ[i].eState);
        end
        expQ.delete(i);
      end
    end
  end

  task automatic finish_run();
    nChecks++;
    if (overlaps != 0) begin
      nFails++;
      $display("FAIL R9 overlap cycles: actual %0d expected 0", overlaps);
    end
    if (expQ.size() != 0) begin
      nFails += expQ.size();
      $display("FAIL scoreboard: actual %0d unchecked items expected 0", expQ.size());
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    finished = 1'b1;
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    waitCyc(5);
    rstN = 1'b1;
    // R1 / R12: reset state
    expectAt(1, 1'b0, 1'b0, 0, 0, "R1 reset");
    waitCyc(4);

    // R2: supply one powers up, near flag low
    s1Uv = 1'b1;
    expectAt(14, 1'b0, 1'b0, 0, 0, "R2 before close delay");
    expectAt(26, 1'b1, 1'b0, 1, 1, "R2 closed after delay, R8 step 1");
    waitCyc(30);
    // R8: step holds while output not near
    expectAt(1, 1'b1, 1'b0, 1, 1, "R8 step held without near");
    waitCyc(3);
    near1 = 1'b1;
    expectAt(9, 1'b1, 1'b0, 2, 1, "R8 step 2");
    expectAt(14, 1'b1, 1'b0, 3, 1, "R8 step 3");
    expectAt(25, 1'b1, 1'b0, 4, 2, "R8 full conduction, connected");
    waitCyc(30);

    // R4 / R5: supply one over-voltage, supply two absent
    s1Hv = 1'b1;
    expectAt(3, 1'b1, 1'b0, -1, 2, "R4 hv before delay");
    expectAt(14, 1'b0, 1'b0, 0, 0, "R4 hv opened, R5 all open");
    waitCyc(20);

    // R3: supply two valid while supply one above hv
    near2 = 1'b0;
    s2Uv = 1'b1;
    expectAt(14, 1'b0, 1'b0, 0, 0, "R3 supply two before delay");
    expectAt(28, 1'b0, 1'b1, 1, 4, "R3 supply two soft start");
    waitCyc(30);
    near2 = 1'b1;
    expectAt(35, 1'b0, 1'b1, 4, 5, "R8 supply two connected");
    waitCyc(40);

    // R6: supply one leaves hv, near1 low -> hand-back waits
    near1 = 1'b0;
    s1Hv = 1'b0;
    expectAt(8, 1'b0, 1'b0, 0, 6, "R6 supply two dropped");
    expectAt(30, 1'b0, 1'b0, 0, 6, "R7 hand-back waits for near");
    waitCyc(32);
    near1 = 1'b1;
    expectAt(8, 1'b1, 1'b0, -1, 1, "R7 hand-back soft start");
    expectAt(35, 1'b1, 1'b0, 4, 2, "R8 connected after hand-back");
    waitCyc(40);

    // R7: hand-over toward supply two waits for near2
    near2 = 1'b0;
    s1Hv = 1'b1;
    expectAt(14, 1'b0, 1'b0, 0, 3, "R7 hand-over waits for near");
    waitCyc(20);
    near2 = 1'b1;
    expectAt(8, 1'b0, 1'b1, -1, 4, "R7 hand-over soft start");
    expectAt(35, 1'b0, 1'b1, 4, 5, "R7 hand-over connected");
    waitCyc(40);

    // back to supply one (near1 already high)
    s1Hv = 1'b0;
    expectAt(35, 1'b1, 1'b0, 4, 2, "R6 return to supply one");
    waitCyc(40);

    // R4: short under-voltage glitch ignored
    s1Uv = 1'b0;
    waitCyc(4);
    s1Uv = 1'b1;
    expectAt(20, 1'b1, 1'b0, 4, 2, "R4 short uv glitch ignored");
    waitCyc(25);

    // R4: persistent under-voltage opens
    s1Uv = 1'b0;
    expectAt(6, 1'b1, 1'b0, -1, 2, "R4 uv before delay");
    expectAt(18, 1'b0, 1'b0, 0, 0, "R4 uv opened");
    waitCyc(20);
    // R3: supply two valid, supply one absent -> stays open
    expectAt(40, 1'b0, 1'b0, 0, 0, "R3 supply two alone not used");
    waitCyc(42);

    // R10: supply one returns while supply two also valid
    s1Uv = 1'b1;
    expectAt(26, 1'b1, 1'b0, -1, 1, "R10 supply one preferred");
    expectAt(60, 1'b1, 1'b0, 4, 2, "R10 supply one connected");
    waitCyc(62);

    // R11: tick held low stalls the lockout
    tick = 1'b0;
    s1Uv = 1'b0;
    expectAt(30, 1'b1, 1'b0, 4, 2, "R11 no tick, no lockout");
    waitCyc(32);
    tick = 1'b1;
    expectAt(20, 1'b0, 1'b0, 0, 0, "R11 lockout after ticks resume");
    waitCyc(25);

    finish_run();
  end

endmodule